// File: doc/BRIEF.md
# Sub-Processor Tick Timer, Stopwatch and Interrupt Mask

This block gives a sub-processor its basic timekeeping and interrupt gating. A free-running prescaler divides the CPU clock by 384 to make a shared tick. That tick drives two counters. The first is an 8-bit interval counter that reloads itself and raises a level-3 request. The second is a 12-bit stopwatch that counts up until software clears it.

A mask register selects which pending levels may reach the processor. The block outputs the highest enabled pending level as a 3-bit priority code. A command-start bit in a control register raises a level-4 request on its rising edge. The processor clears a pending level by presenting that level on the acknowledge input.

Software reaches the block through a small word-wide register bus:

| Address | Register |
|---------|----------|
| 0 | Interval reload |
| 1 | Stopwatch |
| 2 | Mask |
| 3 | Control |
| 4 | Status |

A write takes effect at the clock edge on which `bus_wr` is high. Read data is combinational from the addressed register.

Top module: `subcpu_timer_irq`

## Requirements
- R1: The shared tick fires once every 384 clocks. With a reload value of N, consecutive interval expiries are exactly N*384 clocks apart.
- R2: Writing a nonzero value to the low 8 bits at address 0 loads that value and starts the interval counter. Writing zero stops it, and no further expiries occur. Address 0 reads back the stored value.
- R3: On expiry the interval counter reloads from the stored value and keeps running without further writes.
- R4: An expiry sets the level-3 pending bit only if mask bit 3 (address 2) is 1 at that moment. An expiry with the bit clear leaves nothing pending.
- R5: `irq_level` is the index of the highest set bit among levels 1 to 6 of (pending AND mask), or 0 when none is set. Mask bit n enables level n.
- R6: A mask write changes `irq_level` starting in the cycle right after the write edge. The mask reads back at address 2.
- R7: The stopwatch (address 1) is a 12-bit counter that steps once per tick and wraps from 4095 to 0. It reads as a 16-bit word whose bits 15..12 are zero.
- R8: A write of any data to address 1 clears the stopwatch to zero. The clear wins over a tick on the same edge.
- R9: A write to address 3 that takes bit 2 from 0 to 1 sets the level-4 pending bit. Writing 1 while it is already 1 does nothing. The request shows on `irq_level` only when mask bit 4 is set.
- R10: Address 4 reads bit 7 equal to mask bit 2, and all other bits zero.
- R11: With `ack_valid` high, the pending bit selected by `ack_level` clears at that clock edge. A new set on the same edge takes priority.
- R12: After reset, `irq_level` is 0 and all registers read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_level | input | 3 | Level whose pending bit is cleared |
| irq_level | output | 3 | Highest enabled pending level, 0 if none |

## Verification
Each kind of wrong internal state shows up at the ports in its own way and at its own time.

- A prescaler or reload fault shows as a level-3 request whose spacing differs from N*384 clocks. It is visible on the second expiry, within about two intervals.
- A wrong pending or mask bit shows on `irq_level` in the cycle after the write or acknowledge that exposes it.
- A stopwatch fault stays hidden until the next read of address 1. The bench reads it after a known count of ticks, and again after a full wrap on a fast-prescaler instance.

// File: rtl/subtmr_pkg.sv
package subtmr_pkg;

  localparam int BUS_W     = 16;
  localparam int ADDR_W    = 3;
  localparam int NUM_LVL   = 6;
  localparam int LVL_W     = 3;
  localparam int LVL_TIMER = 3;
  localparam int LVL_CMD   = 4;
  localparam int CMD_BIT   = 2;
  localparam int MIRROR_BIT = 2;
  localparam int STATUS_BIT = 7;

  typedef enum logic [ADDR_W-1:0] {
    A_TIMER  = 3'd0,
    A_STOPW  = 3'd1,
    A_MASK   = 3'd2,
    A_CTRL   = 3'd3,
    A_STATUS = 3'd4
  } reg_addr_e;

  // Highest set index of the request vector, 0 when empty.
  function automatic logic [LVL_W-1:0] top_level(input logic [NUM_LVL:1] req);
    logic [LVL_W-1:0] lvl;
    lvl = '0;
    for (int i = 1; i <= NUM_LVL; i++) begin
      if (req[i]) lvl = LVL_W'(i);
    end
    return lvl;
  endfunction

endpackage

// File: rtl/subtmr_prescale.sv
module subtmr_prescale #(
  parameter int DIV = 384
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_PRESCALE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);  // R1
  AST_PRESCALE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0));  // R1

endmodule

// File: rtl/subtmr_interval.sv
module subtmr_interval #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  output logic         expire,
  output logic [W-1:0] reload_q
);
  logic [W-1:0] reload_d;
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    reload_d = reload_q;
    cnt_d    = cnt_q;
    expire   = 1'b0;
    if (wr_en) begin
      reload_d = wr_val;
      cnt_d    = wr_val;
    end else if (tick && (cnt_q != '0)) begin
      if (cnt_q == W'(1)) begin
        expire = 1'b1;
        cnt_d  = reload_q;
      end else begin
        cnt_d  = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      cnt_q    <= '0;
    end else begin
      reload_q <= reload_d;
      cnt_q    <= cnt_d;
    end
  end

  AST_TMR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_q == '0) |-> !expire);  // R2
  AST_TMR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt_q == $past(reload_q)));  // R3

endmodule

// File: rtl/subtmr_stopwatch.sv
module subtmr_stopwatch #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         clr,
  output logic [W-1:0] count_q
);
  logic [W-1:0] count_d;

  always_comb begin
    if (clr)       count_d = '0;
    else if (tick) count_d = count_q + 1'b1;
    else           count_d = count_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  AST_SW_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count_q == '0));  // R8
  AST_SW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && tick) |=> (count_q == W'($past(count_q) + 1'b1)));  // R7

endmodule

// File: rtl/subtmr_irq_ctrl.sv
module subtmr_irq_ctrl
  import subtmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mask_wr,
  input  logic             ctrl_wr,
  input  logic [7:0]       wdata,
  input  logic             timer_expire,
  input  logic             ack_valid,
  input  logic [LVL_W-1:0] ack_level,
  output logic [7:0]       mask_q,
  output logic             cmd_q,
  output logic [LVL_W-1:0] irq_level
);
  logic [7:0]       mask_d;
  logic             cmd_d;
  logic             cmd_rise;
  logic [NUM_LVL:1] pend_q, pend_d;
  logic [NUM_LVL:1] set_vec, clr_vec, req;

  always_comb begin
    mask_d   = mask_wr ? wdata : mask_q;
    cmd_d    = ctrl_wr ? wdata[CMD_BIT] : cmd_q;
    cmd_rise = ctrl_wr && wdata[CMD_BIT] && !cmd_q;

    set_vec            = '0;
    set_vec[LVL_TIMER] = timer_expire && mask_q[LVL_TIMER];
    set_vec[LVL_CMD]   = cmd_rise;

    clr_vec = '0;
    for (int i = 1; i <= NUM_LVL; i++) begin
      clr_vec[i] = ack_valid && (ack_level == LVL_W'(i));
    end

    pend_d    = (pend_q & ~clr_vec) | set_vec;
    req       = pend_q & mask_q[NUM_LVL:1];
    irq_level = top_level(req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      cmd_q  <= 1'b0;
      pend_q <= '0;
    end else begin
      mask_q <= mask_d;
      cmd_q  <= cmd_d;
      pend_q <= pend_d;
    end
  end

  AST_T3_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q[LVL_TIMER]) |-> $past(mask_q[LVL_TIMER]));  // R4
  AST_CMD_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q[LVL_CMD]) |-> ($past(ctrl_wr) && !$past(cmd_q)));  // R9
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && (ack_level == LVL_W'(LVL_CMD)) && !cmd_rise) |=> !pend_q[LVL_CMD]);  // R11
  AST_LVL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & mask_q[NUM_LVL:1]) == '0) |-> (irq_level == '0));  // R5

endmodule

// File: rtl/subcpu_timer_irq.sv
module subcpu_timer_irq
  import subtmr_pkg::*;
#(
  parameter int TICK_DIV = 384,
  parameter int TMR_W    = 8,
  parameter int SW_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              ack_valid,
  input  logic [LVL_W-1:0]  ack_level,
  output logic [LVL_W-1:0]  irq_level
);
  logic [1:0]       rst_sync_q;
  logic             core_rst_n;
  logic             tick;
  logic             tmr_wr, sw_clr, mask_wr, ctrl_wr;
  logic             expire;
  logic [TMR_W-1:0] reload_q;
  logic [SW_W-1:0]  sw_count;
  logic [7:0]       mask_q;
  logic             cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  always_comb begin
    tmr_wr  = bus_wr && (bus_addr == A_TIMER);
    sw_clr  = bus_wr && (bus_addr == A_STOPW);
    mask_wr = bus_wr && (bus_addr == A_MASK);
    ctrl_wr = bus_wr && (bus_addr == A_CTRL);
  end

  subtmr_prescale #(.DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst_n(core_rst_n), .tick(tick)
  );

  subtmr_interval #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(core_rst_n), .tick(tick),
    .wr_en(tmr_wr), .wr_val(bus_wdata[TMR_W-1:0]),
    .expire(expire), .reload_q(reload_q)
  );

  subtmr_stopwatch #(.W(SW_W)) u_sw (
    .clk(clk), .rst_n(core_rst_n), .tick(tick),
    .clr(sw_clr), .count_q(sw_count)
  );

  subtmr_irq_ctrl u_irq (
    .clk(clk), .rst_n(core_rst_n),
    .mask_wr(mask_wr), .ctrl_wr(ctrl_wr), .wdata(bus_wdata[7:0]),
    .timer_expire(expire), .ack_valid(ack_valid), .ack_level(ack_level),
    .mask_q(mask_q), .cmd_q(cmd_q), .irq_level(irq_level)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_TIMER:  bus_rdata = BUS_W'(reload_q);
      A_STOPW:  bus_rdata = BUS_W'(sw_count);
      A_MASK:   bus_rdata = BUS_W'(mask_q);
      A_CTRL:   bus_rdata[CMD_BIT] = cmd_q;
      A_STATUS: bus_rdata[STATUS_BIT] = mask_q[MIRROR_BIT];
      default:  bus_rdata = '0;
    endcase
  end

  AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!core_rst_n)
    (bus_addr == A_STOPW) |-> (bus_rdata[BUS_W-1:SW_W] == '0));  // R7
  AST_STATUS_MIRROR: assert property (@(posedge clk) disable iff (!core_rst_n)
    (bus_addr == A_STATUS) |-> (bus_rdata[STATUS_BIT] == mask_q[MIRROR_BIT]));  // R10

endmodule

// File: tb/subcpu_timer_irq_tb.sv
`timescale 1ns/1ps
module subcpu_timer_irq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        ack_valid = 1'b0;
  logic [2:0]  ack_level = 3'd0;
  logic [2:0]  irq_level;

  logic        f_wr = 1'b0;
  logic [2:0]  f_addr = 3'd0;
  logic [15:0] f_wdata = 16'h0;
  logic [15:0] f_rdata;
  logic [2:0]  f_irq;

  int n_checks = 0;
  int n_fails  = 0;

  localparam logic [2:0] AD_TMR = 3'd0, AD_SW = 3'd1, AD_MASK = 3'd2,
                         AD_CTRL = 3'd3, AD_STAT = 3'd4;

  always #2.5 clk = ~clk;

  subcpu_timer_irq u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ack_valid(ack_valid),
    .ack_level(ack_level), .irq_level(irq_level)
  );

  subcpu_timer_irq #(.TICK_DIV(4)) u_fast (
    .clk(clk), .rst_n(rst_n), .bus_wr(f_wr), .bus_addr(f_addr),
    .bus_wdata(f_wdata), .bus_rdata(f_rdata), .ack_valid(1'b0),
    .ack_level(3'd0), .irq_level(f_irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic ack(input logic [2:0] l);
    @(negedge clk);
    ack_valid = 1'b1; ack_level = l;
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    chk("R12 irq", 16'(irq_level), 16'h0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk("R12 reg", v, 16'h0);
    end
  endtask

  // R1 R2 R3: interval spacing with reload 2, then stop
  task automatic t_interval;
    logic [15:0] v;
    int k;
    wr(AD_MASK, 16'h0008);
    wr(AD_TMR, 16'h0002);
    rd(AD_TMR, v);
    chk("R2 readback", v, 16'h0002);
    k = 0;
    while (irq_level != 3'd3 && k < 2000) begin @(negedge clk); k++; end
    chk("R2 started", 16'(irq_level), 16'h3);
    for (int r = 0; r < 2; r++) begin
      ack_valid = 1'b1; ack_level = 3'd3;
      k = 0;
      do begin
        @(negedge clk);
        ack_valid = 1'b0;
        k++;
      end while (irq_level != 3'd3 && k < 3000);
      chk(r == 0 ? "R1 spacing" : "R3 reload spacing", 16'(k), 16'd768);
    end
    ack(3'd3);
    wr(AD_TMR, 16'h0000);
    k = 0;
    for (int c = 0; c < 1200; c++) begin
      @(negedge clk);
      if (irq_level != 3'd0) k++;
    end
    chk("R2 stopped", 16'(k), 16'h0);
    wr(AD_MASK, 16'h0000);
  endtask

  // R4: expiry with mask clear leaves nothing pending
  task automatic t_gate;
    int k;
    wr(AD_TMR, 16'h0001);
    repeat (800) @(negedge clk);
    chk("R4 masked irq", 16'(irq_level), 16'h0);
    wr(AD_MASK, 16'h0008);
    chk("R4 no stale pending", 16'(irq_level), 16'h0);
    k = 0;
    while (irq_level != 3'd3 && k < 500) begin @(negedge clk); k++; end
    chk("R4 enabled expiry", 16'(irq_level), 16'h3);
    wr(AD_TMR, 16'h0000);
    ack(3'd3);
    chk("R11 ack 3", 16'(irq_level), 16'h0);
    wr(AD_MASK, 16'h0000);
  endtask

  // R9 R6 R5 R11: command edge, mask reevaluation, priority
  task automatic t_cmd;
    logic [15:0] v;
    wr(AD_CTRL, 16'h0004);
    chk("R9 masked", 16'(irq_level), 16'h0);
    rd(AD_CTRL, v);
    chk("R9 ctrl readback", v, 16'h0004);
    wr(AD_MASK, 16'h0010);
    chk("R6 mask on", 16'(irq_level), 16'h4);
    wr(AD_MASK, 16'h0000);
    chk("R6 mask off", 16'(irq_level), 16'h0);
    wr(AD_MASK, 16'h0010);
    ack(3'd4);
    chk("R11 ack 4", 16'(irq_level), 16'h0);
    wr(AD_CTRL, 16'h0004);
    chk("R9 no edge", 16'(irq_level), 16'h0);
    wr(AD_CTRL, 16'h0000);
    wr(AD_CTRL, 16'h0004);
    chk("R9 new edge", 16'(irq_level), 16'h4);
    wr(AD_MASK, 16'h0018);
    wr(AD_TMR, 16'h0001);
    repeat (400) @(negedge clk);
    chk("R5 four over three", 16'(irq_level), 16'h4);
    wr(AD_TMR, 16'h0000);
    ack(3'd4);
    chk("R5 three remains", 16'(irq_level), 16'h3);
    ack(3'd3);
    chk("R5 none", 16'(irq_level), 16'h0);
    wr(AD_MASK, 16'h0000);
  endtask

  // R10: status mirror
  task automatic t_status;
    logic [15:0] v;
    wr(AD_MASK, 16'h0004);
    rd(AD_STAT, v);
    chk("R10 mirror set", v, 16'h0080);
    wr(AD_MASK, 16'h007B);
    rd(AD_STAT, v);
    chk("R10 mirror clear", v, 16'h0000);
    rd(AD_MASK, v);
    chk("R6 mask readback", v, 16'h007B);
    wr(AD_MASK, 16'h0000);
  endtask

  // R7 R8: stopwatch count, clear, wrap
  task automatic t_stopwatch;
    logic [15:0] v;
    wr(AD_SW, 16'hBEEF);
    repeat (1920) @(negedge clk);
    rd(AD_SW, v);
    chk("R7 five ticks", v, 16'h0005);
    wr(AD_SW, 16'h0001);
    rd(AD_SW, v);
    chk("R8 cleared", v, 16'h0000);
    @(negedge clk);
    f_wr = 1'b1; f_addr = AD_SW; f_wdata = 16'h1234;
    @(negedge clk);
    f_wr = 1'b0;
    repeat (4096 * 4 + 12) @(negedge clk);
    f_addr = AD_SW;
    #1;
    chk("R7 wrap", f_rdata, 16'h0003);
    chk("R7 fast irq idle", 16'(f_irq), 16'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_interval();
    t_gate();
    t_cmd();
    t_status();
    t_stopwatch();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule